// File: doc/BRIEF.md
# Scaled Saturating Pixel Packer

This block turns fixed-point intermediate results, as produced by a pixel arithmetic pipeline, back into compact pixel or fixed-point formats. Each input element is scaled left by an amount taken from a small scale field inside a 64-bit graphics status word. It is then shifted right arithmetically by a fixed amount that depends on the mode, and clamped to the range of the output format. Three packing modes exist. The first turns four signed 16-bit lanes into four unsigned bytes. The second turns two signed 32-bit words into unsigned bytes and merges them into an accumulator operand that is first shifted left by one byte. The third turns two signed 32-bit words into signed 16-bit values.

A caller presents the status word, two 64-bit operands and a mode code, together with a valid strobe. The packed result appears on a registered 64-bit output one cycle later, with its own valid flag. The status register itself lives outside this block. Only its scale field is used here.

Top module: `pixel_pack_sat`

## Requirements
- R1: In lane mode (mode code 0) the scale is status bits 6:3. Each signed 16-bit lane of operand B, where lane k is bits 16k+15:16k, is shifted left by the scale and then arithmetically right by 7, and the result is clamped to 0..255.
- R2: In lane mode, the clamped byte of lane k is placed at result bits 8k+7:8k, and result bits 63:32 are zero.
- R3: In accumulate mode (mode code 1) the scale is status bits 7:3. Each signed 32-bit word of operand B is shifted left by the scale and then arithmetically right by 23, and the result is clamped to 0..255.
- R4: In accumulate mode the result is operand A shifted left by 8 bits, with bits 7:0 and 39:32 replaced by the clamped bytes of word 0 and word 1 respectively.
- R5: In fixed mode (mode code 2) the scale is status bits 7:3. Each signed 32-bit word of operand B is shifted left by the scale and then arithmetically right by 16, and the result is clamped to -32768..32767.
- R6: In fixed mode, the low 16 bits of the clamped value of word k are placed at result bits 16k+15:16k, and result bits 63:32 are zero.
- R7: Scaled values never wrap before clamping. For example, a word of value 1 with scale 31 clamps to 255 in accumulate mode and to 32767 in fixed mode.
- R8: out_valid equals in_valid delayed by one cycle. The result changes only in the cycle after an accepted input and holds its value otherwise.
- R9: After synchronous reset, out_valid is 0 and the result is 0.
- R10: Mode code 3 produces a result of zero.
- R11: Status bits outside the scale field have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| mode | input | 2 | 0 lane, 1 accumulate, 2 fixed, 3 zero |
| status | input | 64 | Graphics status word carrying the scale field |
| opa | input | 64 | Accumulator operand (accumulate mode) |
| opb | input | 64 | Fixed-point source operand |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Packed result |

## Verification
The assertions check the timing rules on every cycle: the one-cycle valid delay, result hold when no input is accepted, zero upper half in the 32-bit-result modes, zero result in the reserved mode, and the shifted accumulator bytes in accumulate mode. The arithmetic itself can only be shown by the bench's scenarios. These scenarios cover per-lane scaling, rounding by truncation, saturation at both ends, wide shifts that would wrap in a narrow datapath, and insensitivity to non-scale status bits. The bench compares each result against its own model.

// File: rtl/pixel_pack_pkg.sv
package pixel_pack_pkg;
  typedef enum logic [1:0] {
    PK_LANE16 = 2'd0,
    PK_WORD32 = 2'd1,
    PK_FIX    = 2'd2,
    PK_RSVD   = 2'd3
  } pk_mode_e;
endpackage

// File: rtl/pack_scale_clamp.sv
// One element: sign-extend, scale left, fixed arithmetic right shift, clamp.
module pack_scale_clamp #(
  parameter int IN_W  = 16,
  parameter int SCL_W = 4,
  parameter int RSH   = 7,
  parameter int LO    = 0,
  parameter int HI    = 255,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  val,
  input  logic        [SCL_W-1:0] scale,
  output logic        [OUT_W-1:0] q
);
  // Wide enough for the largest left shift, so nothing wraps.
  localparam int WIDE = IN_W + (1 << SCL_W);
  localparam logic signed [WIDE-1:0] LO_W = WIDE'(LO);
  localparam logic signed [WIDE-1:0] HI_W = WIDE'(HI);

  logic signed [WIDE-1:0] ext;
  logic signed [WIDE-1:0] shl;
  logic signed [WIDE-1:0] shr;
  logic signed [WIDE-1:0] sat;

  always_comb begin
    ext = WIDE'(val);
    shl = ext <<< scale;
    shr = shl >>> RSH;
    if (shr < LO_W)      sat = LO_W;
    else if (shr > HI_W) sat = HI_W;
    else                 sat = shr;
  end

  assign q = OUT_W'(sat);
endmodule

// File: rtl/pixel_pack_sat.sv
module pixel_pack_sat
  import pixel_pack_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LANE_W  = 16,
  parameter int WORD_W  = 32,
  parameter int SCL16_W = 4,
  parameter int SCL32_W = 5,
  parameter int SCL_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int N_LANE = DATA_W / LANE_W;
  localparam int N_WORD = DATA_W / WORD_W;
  localparam int HALF_W = DATA_W / 2;
  localparam int SCL_HI = SCL_LSB + SCL32_W;

  logic [SCL16_W-1:0] scl16;
  logic [SCL32_W-1:0] scl32;
  logic               unused_status;

  assign scl16 = status[SCL_LSB +: SCL16_W];
  assign scl32 = status[SCL_LSB +: SCL32_W];
  assign unused_status = ^{status[DATA_W-1:SCL_HI], status[SCL_LSB-1:0]};

  logic [7:0]  lane_b [N_LANE];
  logic [7:0]  word_b [N_WORD];
  logic [15:0] fix_h  [N_WORD];

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    pack_scale_clamp #(
      .IN_W(LANE_W), .SCL_W(SCL16_W), .RSH(7), .LO(0), .HI(255), .OUT_W(8)
    ) i_lane (
      .val   (opb[LANE_W*k +: LANE_W]),
      .scale (scl16),
      .q     (lane_b[k])
    );
  end

  for (genvar k = 0; k < N_WORD; k++) begin : g_word
    pack_scale_clamp #(
      .IN_W(WORD_W), .SCL_W(SCL32_W), .RSH(23), .LO(0), .HI(255), .OUT_W(8)
    ) i_byte (
      .val   (opb[WORD_W*k +: WORD_W]),
      .scale (scl32),
      .q     (word_b[k])
    );
    pack_scale_clamp #(
      .IN_W(WORD_W), .SCL_W(SCL32_W), .RSH(16), .LO(-32768), .HI(32767), .OUT_W(16)
    ) i_fix (
      .val   (opb[WORD_W*k +: WORD_W]),
      .scale (scl32),
      .q     (fix_h[k])
    );
  end

  pk_mode_e          mode_e;
  logic [DATA_W-1:0] nxt;

  assign mode_e = pk_mode_e'(mode);

  always_comb begin
    nxt = '0;
    unique case (mode_e)
      PK_LANE16: begin
        for (int k = 0; k < N_LANE; k++) nxt[8*k +: 8] = lane_b[k];
      end
      PK_WORD32: begin
        nxt = opa << 8;
        for (int k = 0; k < N_WORD; k++) nxt[WORD_W*k +: 8] = word_b[k];
      end
      PK_FIX: begin
        for (int k = 0; k < N_WORD; k++) nxt[16*k +: 16] = fix_h[k];
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R8: valid follows input strobe by exactly one cycle
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  // R8: no accepted input, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R2, R6: 32-bit-result modes keep the upper half clear
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == PK_LANE16 || mode == PK_FIX)) |=> result[DATA_W-1:HALF_W] == '0);

  // R4: accumulator bytes move up by one byte
  p_merge_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == PK_WORD32) |=>
      (result[WORD_W-1:8] == $past(opa[WORD_W-9:0])) &&
      (result[DATA_W-1:WORD_W+8] == $past(opa[DATA_W-9:WORD_W])));

  // R10: reserved mode yields zero
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == PK_RSVD) |=> result == '0);
endmodule

// File: tb/test_pixel_pack_sat.sv
`timescale 1ns/1ps
module test_pixel_pack_sat;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  mode;
  logic [63:0] status, opa, opb;
  logic        out_valid;
  logic [63:0] result;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pixel_pack_sat i_pixel_pack_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .status(status), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint sat(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] model(logic [1:0] m, logic [63:0] st,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int s4 = int'(st[6:3]);
    int s5 = int'(st[7:3]);
    longint x;
    case (m)
      2'd0: for (int k = 0; k < 4; k++) begin
        x = longint'($signed(b[16*k +: 16]));
        x = (x <<< s4) >>> 7;
        r[8*k +: 8] = 8'(sat(x, 0, 255));
      end
      2'd1: begin
        r = a << 8;
        for (int k = 0; k < 2; k++) begin
          x = longint'($signed(b[32*k +: 32]));
          x = (x <<< s5) >>> 23;
          r[32*k +: 8] = 8'(sat(x, 0, 255));
        end
      end
      2'd2: for (int k = 0; k < 2; k++) begin
        x = longint'($signed(b[32*k +: 32]));
        x = (x <<< s5) >>> 16;
        r[16*k +: 16] = 16'(sat(x, -32768, 32767));
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one operation at a negedge; result is registered at the next posedge.
  task automatic run(string tag, logic [1:0] m, logic [63:0] st,
                     logic [63:0] a, logic [63:0] b, logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; mode = m; status = st; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'b0, out_valid}, 64'd1);
    check(tag, result, exp);
  endtask

  task automatic run_m(string tag, logic [1:0] m, logic [63:0] st,
                       logic [63:0] a, logic [63:0] b);
    run(tag, m, st, a, b, model(m, st, a, b));
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; mode = '0; status = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid", {63'b0, out_valid}, 64'd0);
    check("R9 result", result, 64'd0);
    rst = 1'b0;

    // R1/R2: scale 0, lanes 0x0100->2, negative->0, 0x7fff->255, 0x0080->1
    run("R1 lane scale0", 2'd0, 64'h0, 64'h0, 64'h0080_7fff_8000_0100, 64'h0000_0000_01ff_0002);
    // R1: scale 1 doubles before the shift: 0x0080->2, 0x00c0->3
    run("R1 lane scale1", 2'd0, 64'h8, 64'h0, 64'h0000_0000_00c0_0080, 64'h0000_0000_0000_0302);
    // R2: placement of distinct bytes, upper half zero
    run("R2 lane place", 2'd0, 64'h0, 64'hffff_ffff_ffff_ffff, 64'h0200_0180_0100_0080, 64'h0000_0000_0403_0201);
    // R3/R4: scale 0, word 0x00800000 -> 1, word1 negative -> 0
    run("R4 merge", 2'd1, 64'h0, 64'h1122_3344_5566_7788, 64'hffff_0000_0080_0000, 64'h2233_4400_6677_8801);
    // R3: upper clamp at 255 and scale 4
    run("R3 word scale4", 2'd1, 64'h20, 64'h0, 64'h0010_0000_7fff_ffff, 64'h0000_0002_0000_00ff);
    // R5/R6: 0x00010000 -> 1, 0xfffe0000 -> -2
    run("R6 fix pack", 2'd2, 64'h0, 64'hffff_ffff_ffff_ffff, 64'hfffe_0000_0001_0000, 64'h0000_0000_fffe_0001);
    // R5: clamp both ends
    run("R5 fix clamp", 2'd2, 64'h0, 64'h0, 64'h8000_0000_7fff_ffff, 64'h0000_0000_8000_7fff);
    // R7: scale 31 on value 1 must not wrap
    run("R7 word wide", 2'd1, 64'hf8, 64'h0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_00ff);
    run("R7 fix wide", 2'd2, 64'hf8, 64'h0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_7fff);
    // R10: reserved mode
    run("R10 rsvd", 2'd3, 64'h18, 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0, 64'h0);
    // R11: non-scale status bits ignored
    run_m("R11 base", 2'd1, 64'h0000_0000_0000_0050, 64'h0102_0304_0506_0708, 64'h0123_4567_0765_4321);
    held = result;
    run("R11 noisy", 2'd1, 64'hdead_beef_1234_5657, 64'h0102_0304_0506_0708, 64'h0123_4567_0765_4321, held);

    // R8: no input, new operands must not change the result
    @(negedge clk);
    held = result;
    mode = 2'd0; opb = 64'h7fff_7fff_7fff_7fff; status = 64'h78;
    @(negedge clk);
    check("R8 out_valid low", {63'b0, out_valid}, 64'd0);
    check("R8 hold", result, held);

    // Random mix over all modes
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      logic [63:0] st = {$urandom, $urandom};
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if (i % 3 == 0) b = b >> $urandom_range(8, 40);
      case (m)
        2'd0: run_m("R1 random lane", m, st, a, b);
        2'd1: run_m("R3 random word", m, st, a, b);
        2'd2: run_m("R5 random fix", m, st, a, b);
        default: run_m("R10 random rsvd", m, st, a, b);
      endcase
    end

    // R9: reset clears after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 result after reset", result, 64'd0);
    rst = 1'b0;

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule